// File: doc/BRIEF.md
# Binary and Packed-Decimal Add/Subtract Unit

This block adds or subtracts two byte-wide operands with a carry input. A decimal flag chooses between plain binary arithmetic and packed-BCD arithmetic, where each operand byte holds two decimal digits. An operation select chooses between add and subtract. The unit returns the result byte, a carry output, and zero and negative flags.

Subtraction treats the carry input as an inverted borrow. A carry output of one after a subtract means that no borrow was needed. In decimal mode each 4-bit digit lane is corrected on its own and the correction ripples from the low digit to the high digit. The same carry therefore signals a decimal wrap past 99 on add, or a decimal borrow on subtract.

The arithmetic itself is combinational. A parameter `REG_OUT` (default 1) places one register stage on all outputs. The design has no state machine. Its only sequential element is that output register, which is cleared by an asynchronous active-low reset. The digit count is a parameter `DIGITS` (default 2, giving an 8-bit datapath).

Top module: `decadd_unit`

## Requirements
- R1: Binary add (decimal=0, subtract=0): result = (op_a + op_b + carry_in) mod 256, and carry_out = bit 8 of that sum.
- R2: Binary subtract (decimal=0, subtract=1): result = (op_a - op_b - (1 - carry_in)) mod 256, and carry_out = 1 exactly when op_a >= op_b + (1 - carry_in).
- R3: Decimal add with valid digits (each nibble 0..9): the result is the two-digit BCD form of (A + B + carry_in) mod 100, where A and B are the decimal values of the operands, and carry_out = 1 when that sum exceeds 99. For example, 0x99 + 0x01 with carry_in=0 gives 0x00 with carry_out=1.
- R4: Decimal subtract with valid digits: the result is the BCD form of (A - B - (1 - carry_in)) mod 100, and carry_out = 1 when no borrow occurred.
- R5: The decimal flag alone selects the mode. 0x99 + 0x01 with carry_in=0 and decimal=0 gives 0x9A with carry_out=0.
- R6: zero is 1 exactly when the 8-bit result is 0x00.
- R7: negative equals bit 7 of the result.
- R8: In decimal mode, nibbles are processed low lane first, and the carry passes from each lane to the next.
  - For a lane add, s = a + b + c. If s > 9, the digit is (s + 6) mod 16 and the lane carry is 1. Otherwise the digit is s and the lane carry is 0.
  - For a lane subtract, s = a + (15 - b) + c. The lane carry is 1 when s >= 16, and then the digit is s mod 16. Otherwise the digit is (s - 6) mod 16.
  - Invalid digits (A..F) follow the same rule.
- R9: With REG_OUT=1, all outputs are 0 while rst_n is low. Outputs change only on a rising clk edge, one cycle after the inputs are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| op_a | input | 8 (4*DIGITS) | First operand (minuend on subtract) |
| op_b | input | 8 (4*DIGITS) | Second operand (subtrahend on subtract) |
| carry_in | input | 1 | Carry in; on subtract, 1 means no borrow in |
| subtract | input | 1 | 1 selects subtract, 0 selects add |
| decimal | input | 1 | 1 selects packed-BCD arithmetic |
| result | output | 8 (4*DIGITS) | Result byte |
| carry_out | output | 1 | Carry out; on subtract, 1 means no borrow |
| zero | output | 1 | Result equals zero |
| negative | output | 1 | Top bit of result |

## Verification
With the default register stage, every output (result, carry_out, zero, negative) is due one rising edge after the operands are applied. The bench drives the inputs on the falling edge. Just before the next rising edge it confirms that the outputs still hold the previous operation's values. On the following falling edge it compares them against its own models. Expected values come from integer decimal arithmetic for valid digits, and from the lane rule of R8 for invalid ones. The stimulus combines directed wrap and borrow cases with seeded random operands, biased toward valid BCD.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [1:0] {
        OP_BIN_ADD = 2'b00,
        OP_BIN_SUB = 2'b01,
        OP_DEC_ADD = 2'b10,
        OP_DEC_SUB = 2'b11
    } op_kind_e;

    localparam int unsigned LANE_W   = 4;
    localparam int unsigned DEC_MAX  = 9;
    localparam int unsigned DEC_FIX  = 6;

endpackage

// File: rtl/addsub_digit.sv
module addsub_digit
    import addsub_pkg::*;
(
    input  op_kind_e          kind,
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    input  logic              cin,
    output logic [LANE_W-1:0] dig,
    output logic              cout
);

    logic [LANE_W-1:0] b_eff;
    logic [LANE_W:0]   lane_sum;
    logic [LANE_W:0]   lane_adj;

    always_comb begin
        b_eff    = (kind == OP_BIN_SUB || kind == OP_DEC_SUB) ? ~b : b;
        lane_sum = {1'b0, a} + {1'b0, b_eff} + {{LANE_W{1'b0}}, cin};
        lane_adj = lane_sum + (LANE_W+1)'(DEC_FIX);
    end

    always_comb begin
        dig  = lane_sum[LANE_W-1:0];
        cout = lane_sum[LANE_W];
        unique case (kind)
            OP_BIN_ADD, OP_BIN_SUB: begin
                dig  = lane_sum[LANE_W-1:0];
                cout = lane_sum[LANE_W];
            end
            OP_DEC_ADD: begin
                if (lane_sum > (LANE_W+1)'(DEC_MAX)) begin
                    dig  = lane_adj[LANE_W-1:0];
                    cout = 1'b1;
                end else begin
                    dig  = lane_sum[LANE_W-1:0];
                    cout = 1'b0;
                end
            end
            OP_DEC_SUB: begin
                cout = lane_sum[LANE_W];
                dig  = lane_sum[LANE_W] ? lane_sum[LANE_W-1:0]
                                        : lane_sum[LANE_W-1:0] - LANE_W'(DEC_FIX);
            end
            default: begin
                dig  = lane_sum[LANE_W-1:0];
                cout = lane_sum[LANE_W];
            end
        endcase
    end

    // Lane checks: valid decimal digits in must give a valid digit out.
    always_comb begin
        if ((kind == OP_DEC_ADD || kind == OP_DEC_SUB) &&
            a <= LANE_W'(DEC_MAX) && b <= LANE_W'(DEC_MAX)) begin
            AST_DEC_DIGIT_VALID: assert (dig <= LANE_W'(DEC_MAX)); // R8
        end
        if (kind == OP_DEC_ADD && a <= LANE_W'(DEC_MAX) && b <= LANE_W'(DEC_MAX)) begin
            AST_DEC_ADD_CARRY: assert (cout == ((5'(a) + 5'(b) + 5'(cin)) > 5'd9)); // R3
        end
    end

endmodule

// File: rtl/addsub_outstage.sv
module addsub_outstage #(
    parameter int unsigned WIDTH   = 8,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] res_c,
    input  logic             cout_c,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o,
    output logic             zero_o,
    output logic             neg_o
);

    logic zero_c;
    logic neg_c;

    assign zero_c = (res_c == '0);
    assign neg_c  = res_c[WIDTH-1];

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    res_o  <= '0;
                    cout_o <= 1'b0;
                    zero_o <= 1'b0;
                    neg_o  <= 1'b0;
                end else begin
                    res_o  <= res_c;
                    cout_o <= cout_c;
                    zero_o <= zero_c;
                    neg_o  <= neg_c;
                end
            end

            AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (res_o == $past(res_c) && cout_o == $past(cout_c))); // R9
        end else begin : g_comb
            assign res_o  = res_c;
            assign cout_o = cout_c;
            assign zero_o = zero_c;
            assign neg_o  = neg_c;
        end
    endgenerate

endmodule

// File: rtl/decadd_unit.sv
module decadd_unit
    import addsub_pkg::*;
#(
    parameter int unsigned DIGITS  = 2,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [4*DIGITS-1:0]      op_a,
    input  logic [4*DIGITS-1:0]      op_b,
    input  logic                     carry_in,
    input  logic                     subtract,
    input  logic                     decimal,
    output logic [4*DIGITS-1:0]      result,
    output logic                     carry_out,
    output logic                     zero,
    output logic                     negative
);

    localparam int unsigned WIDTH = LANE_W * DIGITS;

    op_kind_e         kind;
    logic [DIGITS:0]  chain;
    logic [WIDTH-1:0] res_c;

    always_comb begin
        unique case ({decimal, subtract})
            2'b00:   kind = OP_BIN_ADD;
            2'b01:   kind = OP_BIN_SUB;
            2'b10:   kind = OP_DEC_ADD;
            2'b11:   kind = OP_DEC_SUB;
            default: kind = OP_BIN_ADD;
        endcase
    end

    assign chain[0] = carry_in;

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_lane
            addsub_digit u_dig (
                .kind (kind),
                .a    (op_a[LANE_W*g +: LANE_W]),
                .b    (op_b[LANE_W*g +: LANE_W]),
                .cin  (chain[g]),
                .dig  (res_c[LANE_W*g +: LANE_W]),
                .cout (chain[g+1])
            );
        end
    endgenerate

    // Binary mode must match a full-width ripple of the lanes.
    always_comb begin
        if (!decimal && !subtract) begin
            AST_BIN_ADD_WIDE: assert ({chain[DIGITS], res_c} ==
                ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in})); // R1
        end
    end

    addsub_outstage #(
        .WIDTH   (WIDTH),
        .REG_OUT (REG_OUT)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .res_c  (res_c),
        .cout_c (chain[DIGITS]),
        .res_o  (result),
        .cout_o (carry_out),
        .zero_o (zero),
        .neg_o  (negative)
    );

    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        zero |-> !negative); // R6

    AST_NEG_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        negative |-> (result != '0)); // R7

endmodule

// File: tb/decadd_unit_tb.sv
module decadd_unit_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] op_a, op_b;
    logic       carry_in, subtract, decimal;
    logic [7:0] result;
    logic       carry_out, zero, negative;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [8:0] prev_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    decadd_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .subtract(subtract), .decimal(decimal),
        .result(result), .carry_out(carry_out), .zero(zero), .negative(negative)
    );

    function automatic bit is_bcd(input logic [7:0] v);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
    endfunction

    // Lane rule of R8, for any nibble values.
    function automatic logic [8:0] lane_model(input logic [7:0] a, input logic [7:0] b,
                                              input logic c, input logic sub);
        int cy = c;
        logic [7:0] r = '0;
        for (int i = 0; i < 2; i++) begin
            int na = (a >> (4*i)) & 15;
            int nb = (b >> (4*i)) & 15;
            int s;
            int d;
            if (sub) begin
                s  = na + (15 - nb) + cy;
                cy = (s >= 16) ? 1 : 0;
                d  = cy ? (s & 15) : ((s - 6) & 15);
            end else begin
                s = na + nb + cy;
                if (s > 9) begin d = (s + 6) & 15; cy = 1; end
                else       begin d = s;            cy = 0; end
            end
            r[4*i +: 4] = 4'(d);
        end
        return {cy[0], r};
    endfunction

    function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                         input logic c, input logic sub, input logic dec);
        int x;
        if (!dec) begin
            if (!sub) begin
                x = int'(a) + int'(b) + int'(c);
                return {x >= 256, 8'(x)};
            end
            x = int'(a) - int'(b) - (1 - int'(c));
            return {x >= 0, 8'(x)};
        end
        if (is_bcd(a) && is_bcd(b)) begin
            int va = a[7:4]*10 + a[3:0];
            int vb = b[7:4]*10 + b[3:0];
            bit cy;
            if (!sub) begin
                x = va + vb + int'(c);
                cy = (x > 99);
                if (cy) x -= 100;
            end else begin
                x = va - vb - (1 - int'(c));
                cy = (x >= 0);
                if (!cy) x += 100;
            end
            return {cy, 4'(x / 10), 4'(x % 10)};
        end
        return lane_model(a, b, c, sub);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic c,
                         input logic sub, input logic dec, input string tag);
        logic [8:0] e;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c; subtract = sub; decimal = dec;
        e = model(a, b, c, sub, dec);
        #(CLK_PERIOD/2 - 1);
        // R9: nothing moves before the rising edge
        check("R9 hold", {23'd0, carry_out, result}, {23'd0, prev_exp});
        @(negedge clk);
        check(tag, {23'd0, carry_out, result}, {23'd0, e});
        check("R6 zero", {31'd0, zero}, {31'd0, e[7:0] == 8'h00});
        check("R7 negative", {31'd0, negative}, {31'd0, e[7]});
        prev_exp = e;
    endtask

    function automatic string tag_of(input logic [7:0] a, input logic [7:0] b,
                                     input logic sub, input logic dec);
        if (!dec) return sub ? "R2 bin sub" : "R1 bin add";
        if (!(is_bcd(a) && is_bcd(b))) return "R8 lane rule";
        return sub ? "R4 dec sub" : "R3 dec add";
    endfunction

    initial begin
        rst_n = 1'b0;
        op_a = 8'h55; op_b = 8'h22; carry_in = 1'b1; subtract = 1'b0; decimal = 1'b0;
        prev_exp = 9'h000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check("R9 reset", {28'd0, result[3:0] | result[7:4], carry_out, zero, negative}, 32'd0);
        check("R9 reset result", {24'd0, result}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        prev_exp = model(8'h55, 8'h22, 1'b1, 1'b0, 1'b0);

        apply(8'h99, 8'h01, 1'b0, 1'b0, 1'b1, "R3 dec 99+01");
        check("R3 wrap", {23'd0, carry_out, result}, {23'd0, 9'h100});
        apply(8'h99, 8'h01, 1'b0, 1'b0, 1'b0, "R5 bin 99+01");
        check("R5 mode", {23'd0, carry_out, result}, {23'd0, 9'h09A});
        apply(8'h00, 8'h01, 1'b1, 1'b1, 1'b1, "R4 dec 00-01");
        check("R4 borrow", {23'd0, carry_out, result}, {23'd0, 9'h099});
        apply(8'h50, 8'h25, 1'b0, 1'b1, 1'b1, "R4 dec borrow-in");
        apply(8'h45, 8'h45, 1'b1, 1'b1, 1'b1, "R4 dec equal");
        apply(8'h49, 8'h51, 1'b1, 1'b0, 1'b1, "R3 dec carry-in");
        apply(8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, "R1 bin wrap");
        apply(8'h00, 8'h00, 1'b1, 1'b0, 1'b0, "R1 carry-in");
        apply(8'h10, 8'h20, 1'b1, 1'b1, 1'b0, "R2 bin borrow");
        apply(8'h80, 8'h80, 1'b1, 1'b1, 1'b0, "R2 bin equal");
        apply(8'hAF, 8'h3C, 1'b1, 1'b0, 1'b1, "R8 invalid add");
        apply(8'hFA, 8'hB7, 1'b0, 1'b1, 1'b1, "R8 invalid sub");

        void'($urandom(32'd20240611));
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a, b;
            logic c, s, d;
            d = 1'($urandom);
            s = 1'($urandom);
            c = 1'($urandom);
            if (d && ($urandom % 10) < 7) begin
                a = {4'($urandom % 10), 4'($urandom % 10)};
                b = {4'($urandom % 10), 4'($urandom % 10)};
            end else begin
                a = 8'($urandom);
                b = 8'($urandom);
            end
            apply(a, b, c, s, d, tag_of(a, b, s, d));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule